// File: doc/BRIEF.md
# Double-Buffered Audio Playback DMA

The block plays audio from memory. Software programs a start address and a byte
length for a buffer. The block fetches that buffer as 64-bit words over a simple
read port and keeps them in a small sample FIFO. At a programmable sample rate it
sends stereo frames of signed 16-bit samples, most significant byte first, to a
serial DAC pin set. That pin set has a bit clock, a left/right select and a data line.

The address and length registers form a two-entry queue. One buffer plays while
the next one waits behind it. When an entry becomes the playing buffer, the block
raises an interrupt request. Software uses that request to refill the free slot,
so the queue always holds two buffers. Any write to the status register drops the
request.

A rate divider sets the sample period in system clocks. Software derives its value
from the 48 681 812 Hz converter clock: the rounded clock/rate ratio minus one,
for rates from 8 kHz to 48 kHz. A second divider sets the bit-clock half period.
When the queue runs dry, the output keeps repeating the last sample.

Top module: `audio_dma_out`

## Requirements
- R1: After reset, status reads 0, irq is low, mem_req is low, and dac_bclk and dac_sdata are 0.
- R2: Word offsets on reg_addr: 0 is the pending address, 1 is the pending length, 2 is control with bit 0 as enable, 3 is status, 4 is the rate divider and 5 is the bit-clock divider. Offsets 0, 1, 2, 4 and 5 read back what was written; address bits 2:0 read back as 0.
- R3: Writing the length register commits the pending address and length into the two-entry queue. Status bit 31 (full) is 1 while both entries are occupied. A length write while full is ignored, and so is a length whose 8-byte word count is zero.
- R4: irq (also status bit 0) is set when an entry becomes the playing buffer. That happens either when a write lands in an empty queue or when the waiting entry is promoted after the last word of the playing buffer has been fetched. Any write to offset 3 clears irq.
- R5: While enabled, with a playing buffer and room in the FIFO, mem_req is high. mem_addr steps by 8 bytes from the buffer start and holds its value until mem_ack; each word is taken in the cycle mem_ack is high.
- R6: While enabled, a sample tick occurs every rate+1 clocks. Each fetched 64-bit word yields two stereo samples, bits 63:32 first. Within a sample, the left channel is the upper 16 bits.
- R7: Each tick starts a 32-bit frame, sent MSB first. dac_sdata changes on falling edges of dac_bclk and is valid on rising edges. dac_bclk stays high for bdiv+1 clocks per bit. dac_lrclk is 0 for the 16 left bits and 1 for the 16 right bits. dac_bclk idles low between frames.
- R8: Once all queued data has been sent, status bit 30 (busy) reads 0 and every further frame repeats the last sample.
- R9: With enable at 0, no memory request is made and no new frame starts.
- R10: A queued buffer's samples follow those of the previous buffer with no gap and no repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW (24) | Byte address of the 64-bit word requested |
| mem_ack | input | 1 | Memory response strobe; mem_rdata valid |
| mem_rdata | input | 64 | Memory read data |
| dac_bclk | output | 1 | Serial bit clock |
| dac_lrclk | output | 1 | Channel select: 0 left, 1 right |
| dac_sdata | output | 1 | Serial sample data |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that ends its write cycle. Status,
irq and queue effects are therefore read at the next falling edge. Memory words are
compared in the cycle mem_ack is high. Serial bits are captured on each rising
dac_bclk, seen at falling clock edges. A scoreboard pops one expected sample per
32-bit frame. Frame starts are checked to lie exactly rate+1 clocks apart, and
dac_bclk high phases to last exactly bdiv+1 clocks, counted on the same falling edges.

// File: rtl/audio_dma_out.sv
module audio_dma_out #(
  parameter int AW = 24,
  parameter int LW = 18,
  parameter int RW = 16,
  parameter int BW = 8,
  parameter int FD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata,
  output logic          dac_bclk,
  output logic          dac_lrclk,
  output logic          dac_sdata,
  output logic          irq
);
  localparam int WA = AW - 3;
  localparam int WN = LW - 3;
  localparam int PW = (FD > 1) ? $clog2(FD) : 1;
  localparam int CW = $clog2(FD + 1);

  logic [WA-1:0] pend_a, s0_a, s1_a;
  logic [LW-1:0] pend_len;
  logic [WN-1:0] s0_n, s1_n;
  logic          en, s0_v, s1_v, irq_q;
  logic [RW-1:0] rate, rcnt;
  logic [BW-1:0] bdiv, bcnt;

  logic [63:0]   fifo [FD];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  logic          half, active, bclk_q;
  logic [31:0]   lo_save, cur_smp, shreg, nxt_smp;
  logic [4:0]    bit_i;

  wire unused_ok = &{1'b0, reg_wdata};

  wire w_addr = reg_we && reg_addr == 3'd0;
  wire w_len  = reg_we && reg_addr == 3'd1;
  wire w_ctl  = reg_we && reg_addr == 3'd2;
  wire w_stat = reg_we && reg_addr == 3'd3;
  wire w_rate = reg_we && reg_addr == 3'd4;
  wire w_bdiv = reg_we && reg_addr == 3'd5;

  wire [WN-1:0] wlen = reg_wdata[LW-1:3];
  wire full  = s0_v & s1_v;
  wire push  = w_len & ~full & (wlen != '0);
  wire take  = mem_req & mem_ack;
  wire last  = take & (s0_n == WN'(1));
  wire to_s0 = ~s0_v | (last & ~s1_v);
  wire fnz   = cnt != '0;
  wire busy  = s0_v | fnz | half;
  wire tick  = en & (rcnt >= rate);
  wire pop   = tick & ~half & fnz;

  assign mem_req   = en & s0_v & (cnt != CW'(FD));
  assign mem_addr  = {s0_a, 3'b000};
  assign dac_bclk  = bclk_q;
  assign dac_lrclk = bit_i[4];
  assign dac_sdata = shreg[31];
  assign irq       = irq_q;
  assign nxt_smp   = half ? lo_save : (fnz ? fifo[rp][63:32] : cur_smp);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'({pend_a, 3'b000});
      3'd1:    reg_rdata = 32'(pend_len);
      3'd2:    reg_rdata = {31'b0, en};
      3'd3:    reg_rdata = {full, busy, 29'b0, irq_q};
      3'd4:    reg_rdata = 32'(rate);
      3'd5:    reg_rdata = 32'(bdiv);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a <= '0; pend_len <= '0; en <= 1'b0; rate <= '0; bdiv <= '0;
      s0_v <= 1'b0; s1_v <= 1'b0; s0_a <= '0; s1_a <= '0;
      s0_n <= '0; s1_n <= '0; irq_q <= 1'b0;
    end else begin
      if (w_addr) pend_a <= reg_wdata[AW-1:3];
      if (w_len)  pend_len <= reg_wdata[LW-1:0];
      if (w_ctl)  en <= reg_wdata[0];
      if (w_rate) rate <= reg_wdata[RW-1:0];
      if (w_bdiv) bdiv <= reg_wdata[BW-1:0];
      if (take) begin
        s0_a <= s0_a + WA'(1);
        s0_n <= s0_n - WN'(1);
      end
      if (last) begin
        s0_v <= s1_v; s0_a <= s1_a; s0_n <= s1_n; s1_v <= 1'b0;
      end
      if (push) begin
        if (to_s0) begin
          s0_v <= 1'b1; s0_a <= pend_a; s0_n <= wlen;
        end else begin
          s1_v <= 1'b1; s1_a <= pend_a; s1_n <= wlen;
        end
      end
      if ((push & to_s0) | (last & s1_v)) irq_q <= 1'b1;
      else if (w_stat)                    irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) fifo[wp] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (take) wp <= (wp == PW'(FD - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(FD - 1)) ? '0 : rp + PW'(1);
      case ({take, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0; half <= 1'b0; lo_save <= '0; cur_smp <= '0; shreg <= '0;
      active <= 1'b0; bit_i <= '0; bcnt <= '0; bclk_q <= 1'b0;
    end else begin
      if (!en || tick) rcnt <= '0;
      else             rcnt <= rcnt + RW'(1);
      if (tick) begin
        cur_smp <= nxt_smp;
        shreg   <= nxt_smp;
        if (half) half <= 1'b0;
        else if (fnz) begin
          half    <= 1'b1;
          lo_save <= fifo[rp][31:0];
        end
        active <= 1'b1;
        bit_i  <= '0;
        bcnt   <= '0;
        bclk_q <= 1'b0;
      end else if (active) begin
        if (bcnt == bdiv) begin
          bcnt   <= '0;
          bclk_q <= ~bclk_q;
          if (bclk_q) begin
            shreg <= {shreg[30:0], 1'b0};
            bit_i <= bit_i + 5'd1;
            if (bit_i == 5'd31) active <= 1'b0;
          end
        end else begin
          bcnt <= bcnt + BW'(1);
        end
      end
    end
  end
endmodule

module audio_dma_out_chk #(
  parameter int AW = 24,
  parameter int CW = 3,
  parameter int FD = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          s0_v,
  input logic          s1_v,
  input logic          last,
  input logic          stat_wr,
  input logic          irq,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] cnt,
  input logic          active,
  input logic          bclk
);
  p_slot_order_r3: assert property (@(posedge clk) disable iff (!rst_n) !s0_v |-> !s1_v);
  p_fifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(FD));
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr));
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !mem_req);
  p_irq_promote_r4: assert property (@(posedge clk) disable iff (!rst_n) last && s1_v |=> irq);
  p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq) |-> $past(stat_wr));
  p_bclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n) !active |-> !bclk);
endmodule

bind audio_dma_out audio_dma_out_chk #(.AW(AW), .CW(CW), .FD(FD)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .s0_v(s0_v), .s1_v(s1_v), .last(last),
  .stat_wr(w_stat), .irq(irq), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .cnt(cnt), .active(active), .bclk(dac_bclk)
);

// File: tb/sim_audio_dma_out.sv
module sim_audio_dma_out;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_ack;
  logic [23:0] mem_addr;
  logic [63:0] mem_rdata;
  logic dac_bclk, dac_lrclk, dac_sdata, irq;

  always #4 clk = ~clk;

  audio_dma_out u0 (.*);

  int nchk = 0, nerr = 0, cyc = 0, frames = 0;
  logic [31:0] exp_s [$];
  logic [23:0] exp_a [$];
  logic [31:0] last_s = 0;
  int exp_rate = 0, exp_bdiv = 0;
  bit gap_ok = 0, done = 0;

  function automatic logic [63:0] memval(input logic [23:0] a);
    logic [15:0] w;
    w = 16'(a[23:3]);
    return {16'h1000 + w, 16'h2000 + w, 16'h3000 + w, 16'h4000 + w};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) mem_ack <= 0;
    else mem_ack <= mem_req & !mem_ack;
    mem_rdata <= memval(mem_addr);
  end

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (exp_a.size() == 0) check("R5 unexpected fetch", {8'h0, mem_addr}, 32'hffffffff);
      else check("R5 fetch address", {8'h0, mem_addr}, {8'h0, exp_a.pop_front()});
    end
  end

  logic prev_bclk = 0;
  int bitn = 0, hi_cnt = 0, t0 = 0;
  logic [31:0] fr = 0;
  bit lr_bad = 0;
  always @(negedge clk) begin
    logic [31:0] e;
    if (dac_bclk) hi_cnt++;
    if (!dac_bclk && prev_bclk) begin
      check("R7 bclk high time", hi_cnt, exp_bdiv + 1);
      hi_cnt = 0;
    end
    if (dac_bclk && !prev_bclk) begin
      if (bitn == 0) begin
        if (gap_ok) check("R6 tick interval", cyc - t0, exp_rate + 1);
        t0 = cyc;
        gap_ok = 1;
        lr_bad = 0;
      end
      if (dac_lrclk !== (bitn >= 16)) lr_bad = 1;
      fr = {fr[30:0], dac_sdata};
      bitn++;
      if (bitn == 32) begin
        e = (exp_s.size() != 0) ? exp_s.pop_front() : last_s;
        last_s = e;
        check("R10 R6 R8 frame sample", fr, e);
        check("R7 lrclk phases", {31'b0, lr_bad}, 0);
        frames++;
        bitn = 0;
      end
    end
    prev_bclk = dac_bclk;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic queue_buf(input logic [23:0] a, input int len, input bit accepted);
    wr(3'd0, {8'h0, a});
    wr(3'd1, len);
    if (accepted)
      for (int i = 0; i < len / 8; i++) begin
        logic [63:0] w;
        w = memval(a + 24'(8 * i));
        exp_a.push_back(a + 24'(8 * i));
        exp_s.push_back(w[63:32]);
        exp_s.push_back(w[31:0]);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] d;
    int fc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd3, d); check("R1 status after reset", d, 0);
    check("R1 irq after reset", {31'b0, irq}, 0);
    check("R1 mem_req after reset", {31'b0, mem_req}, 0);
    check("R1 serial idle", {30'b0, dac_bclk, dac_sdata}, 0);

    wr(3'd4, 149); exp_rate = 149;
    wr(3'd5, 1);   exp_bdiv = 1;
    rd(3'd4, d); check("R2 rate readback", d, 149);
    rd(3'd5, d); check("R2 bdiv readback", d, 1);
    wr(3'd0, 32'h105);
    rd(3'd0, d); check("R2 address readback aligned", d, 32'h100);

    queue_buf(24'h100, 32, 1);
    rd(3'd1, d); check("R2 length readback", d, 32);
    check("R4 irq on first entry", {31'b0, irq}, 1);
    rd(3'd3, d); check("R4 R3 status busy+irq", d, 32'h40000001);
    wr(3'd3, 0);
    check("R4 irq cleared by status write", {31'b0, irq}, 0);
    queue_buf(24'h800, 24, 1);
    rd(3'd3, d); check("R3 full with two entries", d[31:30], 2'b11);
    check("R4 no irq for waiting entry", {31'b0, irq}, 0);
    queue_buf(24'h400, 16, 0);
    rd(3'd3, d); check("R3 still full after ignored write", d[31], 1);
    check("R9 no fetch while disabled", {31'b0, mem_req}, 0);

    wr(3'd2, 1);
    rd(3'd2, d); check("R2 control readback", d, 1);
    for (int i = 0; i < 60 && !irq; i++) @(negedge clk);
    check("R4 irq on promotion", {31'b0, irq}, 1);
    rd(3'd3, d); check("R3 not full after promotion", d[31], 0);
    wr(3'd3, 0);
    queue_buf(24'h600, 4, 0);
    rd(3'd3, d); check("R3 zero word length ignored", d[31], 0);
    check("R4 no irq from ignored write", {31'b0, irq}, 0);
    queue_buf(24'h300, 8, 1);
    rd(3'd3, d); check("R3 full again", d[31], 1);

    while (exp_s.size() != 0) @(negedge clk);
    repeat (400) @(negedge clk);
    rd(3'd3, d); check("R8 busy clear after drain", d[30], 0);

    wr(3'd2, 0); gap_ok = 0;
    repeat (200) @(negedge clk);
    fc = frames;
    queue_buf(24'h1000, 40, 1);
    repeat (1000) @(negedge clk);
    check("R9 no frames while disabled", frames, fc);
    check("R9 no fetch while disabled", {31'b0, mem_req}, 0);

    wr(3'd4, 99); exp_rate = 99;
    wr(3'd5, 0);  exp_bdiv = 0;
    wr(3'd2, 1);
    while (exp_s.size() != 0) @(negedge clk);
    repeat (300) @(negedge clk);
    rd(3'd3, d); check("R8 busy clear after second drain", d[30], 0);
    check("R5 all fetches seen", exp_a.size(), 0);
    report();
  end
endmodule